// File: doc/BRIEF.md
# Paged NIC Command and Interrupt Unit

This block is the host-facing control core of a small Ethernet controller. The host reaches it through a 16-byte register window. Offset 0 is the command register, and it is present on every page. The two top bits of the command register choose which bank of registers the other fifteen offsets reach.

The unit holds the run-control bits, an 8-bit interrupt status register and an 8-bit interrupt mask, and drives one level interrupt line. It keeps a transmit start page and a 16-bit transmit byte count. When the host commands a transmit, it hands them to an external transmit path as a single-cycle pulse. A read strobe on a separate reset port performs a soft reset. Other parts of the controller report events through a set-bit vector into the status register.

Top module: `nic_ctrl_core`

## Requirements
- R1: After the reset input is released, the command register reads 0x01 (stopped, page 0), the interrupt status reads 0x80, the mask is 0, `irq` is low and `tx_start` is low.
- R2: Command bits 7:6 select the page used for offsets 1 to 15: 0, 1 or 2, with 3 invalid. Offset 0 always accesses the command register, and it reads back the same on every page.
- R3: On page 1, offsets 1 to 15 are fifteen independent read/write bytes. They hold the six station-address bytes at 1 to 6, the current-page byte at 7 and the eight multicast-filter bytes at 8 to 15. Writes to these bytes do not change page-0 registers.
- R4: While page 3 is selected, writes to offsets 1 to 15 change no register, and reads of those offsets return 0.
- R5: The interrupt status register is read at page 0 offset 7. A host write there clears every status bit written as 1 and leaves the others unchanged.
- R6: Each bit set on `hw_set` sets the same status bit at the next clock edge. If the same bit is also cleared by the host in that cycle, the set wins.
- R7: The mask is written at page 0 offset 15 and read at page 2 offset 15. `irq` is high exactly when (status AND mask) is nonzero, and it follows the registered values with no further delay.
- R8: The transmit count low byte is written at page 0 offset 5 and the high byte at offset 6, and each write replaces only its own half. The transmit start page is written at page 0 offset 4 and read back at page 2 offset 4.
- R9: A command write containing START (0x02) and TRANSMIT (0x04) raises `tx_start` for exactly one cycle, starting one cycle later, with `tx_addr` = start page × 256 and `tx_len` = the count. The same edge sets status bit TX (0x02) and makes the transmit status at page 0 offset 4 read 0x01. TRANSMIT without START produces no pulse.
- R10: A cycle with `rst_port_rd` high sets the status register to exactly 0x80 and the command register to 0x01. The mask, the transmit settings and the page-1 bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Offset within the register window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` on the current page |
| rst_port_rd | input | 1 | Read strobe of the reset port, triggers soft reset |
| hw_set | input | 8 | Event bits to set in interrupt status |
| irq | output | 1 | Level interrupt |
| tx_start | output | 1 | One-cycle transmit request |
| tx_addr | output | 16 | Buffer byte address of the frame |
| tx_len | output | 16 | Frame byte count |

## Verification
Every register write, `hw_set` pulse and reset-port strobe takes effect at the clock edge on which it is sampled. Read data and `irq` are combinational from the registers, so they are due just after that edge. The `tx_start` pulse comes from a register loaded on the command write edge, so it is high in the cycle after that edge and low in the cycle after that. The bench drives inputs on falling edges and samples on the next falling edge, which puts every check half a cycle after the edge on which its result is due. It also checks the pulse in both of its cycles.

// File: rtl/nic_ctrl_pkg.sv
`timescale 1ns/1ps
package nic_ctrl_pkg;
    localparam int DW   = 8;
    localparam int OFFW = 4;
    localparam int IDXW = OFFW + 2;

    // command bits
    localparam logic [DW-1:0] CMD_STOP  = 8'h01;
    localparam logic [DW-1:0] CMD_START = 8'h02;
    localparam logic [DW-1:0] CMD_XMIT  = 8'h04;

    // interrupt status bits
    localparam logic [DW-1:0] IST_TX    = 8'h02;
    localparam logic [DW-1:0] IST_RESET = 8'h80;

    localparam logic [DW-1:0] TXST_OK   = 8'h01;

    // register indices: {page, offset}
    localparam logic [IDXW-1:0] IX_TXPAGE = 6'h04;
    localparam logic [IDXW-1:0] IX_CNTLO  = 6'h05;
    localparam logic [IDXW-1:0] IX_CNTHI  = 6'h06;
    localparam logic [IDXW-1:0] IX_STATUS = 6'h07;
    localparam logic [IDXW-1:0] IX_MASK   = 6'h0F;
    localparam logic [IDXW-1:0] IX_TXPG_R = 6'h24;
    localparam logic [IDXW-1:0] IX_MASK_R = 6'h2F;

    typedef struct packed {
        logic [DW-1:0]   cmd;
        logic [DW-1:0]   mask;
        logic [DW-1:0]   txpage;
        logic [2*DW-1:0] txcnt;
        logic [DW-1:0]   txstat;
        logic            tx_go;
        logic [2*DW-1:0] tx_addr;
        logic [2*DW-1:0] tx_len;
    } core_s;

    function automatic logic [IDXW-1:0] make_index(input logic [1:0] page,
                                                   input logic [OFFW-1:0] off);
        return {page, off};
    endfunction
endpackage

// File: rtl/nic_bank_regs.sv
`timescale 1ns/1ps
module nic_bank_regs #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [NREG-1:0][DW-1:0] bytes_q;

    assign bytes_q[0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_byte
        logic [DW-1:0] byte_d, byte_r;
        always_comb begin
            byte_d = byte_r;
            if (we && waddr == IW'(i))
                byte_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_r <= '0;
            else        byte_r <= byte_d;
        end
        assign bytes_q[i] = byte_r;
    end

    assign rdata = bytes_q[raddr];
endmodule

// File: rtl/nic_isr_unit.sv
`timescale 1ns/1ps
module nic_isr_unit #(
    parameter int                 W         = 8,
    parameter logic [W-1:0]       RESET_VAL = 8'h80,
    parameter logic [W-1:0]       TX_BIT    = 8'h02
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_bits,
    input  logic         tx_done,
    input  logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_we)
            status_d = status_d & ~clr_bits;
        status_d = status_d | set_bits;
        if (tx_done)
            status_d = status_d | TX_BIT;
        if (soft_rst)
            status_d = RESET_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= RESET_VAL;
        else        status_q <= status_d;
    end

    assign status = status_q;
    assign irq    = |(status_q & mask);
endmodule

// File: rtl/nic_ctrl_core.sv
`timescale 1ns/1ps
module nic_ctrl_core
    import nic_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            rst_port_rd,
    input  logic [7:0]      hw_set,
    output logic            irq,
    output logic            tx_start,
    output logic [15:0]     tx_addr,
    output logic [15:0]     tx_len
);
    localparam int NBANK = 1 << OFFW;

    core_s          st_d, st_q;
    logic [1:0]     page;
    logic [IDXW-1:0] idx;
    logic           cmd_hit, valid_page;
    logic           status_clr, bank_we, tx_now;
    logic [DW-1:0]  isr_q, bank_rdata;

    assign page       = st_q.cmd[DW-1 -: 2];
    assign idx        = make_index(page, reg_addr);
    assign cmd_hit    = (reg_addr == '0);
    assign valid_page = (page != 2'd3);
    assign status_clr = reg_wr && !cmd_hit && idx == IX_STATUS;
    assign bank_we    = reg_wr && !cmd_hit && page == 2'd1;
    assign tx_now     = reg_wr && cmd_hit &&
                        ((reg_wdata & (CMD_START | CMD_XMIT)) == (CMD_START | CMD_XMIT));

    always_comb begin
        st_d       = st_q;
        st_d.tx_go = 1'b0;
        if (reg_wr && cmd_hit) begin
            st_d.cmd = reg_wdata;
        end else if (reg_wr && valid_page) begin
            case (idx)
                IX_TXPAGE: st_d.txpage = reg_wdata;
                IX_CNTLO:  st_d.txcnt[DW-1:0]    = reg_wdata;
                IX_CNTHI:  st_d.txcnt[2*DW-1:DW] = reg_wdata;
                IX_MASK:   st_d.mask = reg_wdata;
                default:   ;
            endcase
        end
        if (tx_now) begin
            st_d.tx_go   = 1'b1;
            st_d.tx_addr = {st_q.txpage, {DW{1'b0}}};
            st_d.tx_len  = st_q.txcnt;
            st_d.txstat  = TXST_OK;
        end
        if (rst_port_rd)
            st_d.cmd = CMD_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmd <= CMD_STOP;
        end else begin
            st_q <= st_d;
        end
    end

    nic_isr_unit #(.W(DW), .RESET_VAL(IST_RESET), .TX_BIT(IST_TX)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (rst_port_rd),
        .clr_we   (status_clr),
        .clr_bits (reg_wdata),
        .set_bits (hw_set),
        .tx_done  (tx_now),
        .mask     (st_q.mask),
        .status   (isr_q),
        .irq      (irq)
    );

    nic_bank_regs #(.NREG(NBANK), .DW(DW)) u_bank1 (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (reg_addr),
        .wdata (reg_wdata),
        .raddr (reg_addr),
        .rdata (bank_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (cmd_hit)
            reg_rdata = st_q.cmd;
        else if (page == 2'd1)
            reg_rdata = bank_rdata;
        else begin
            case (idx)
                IX_TXPAGE: reg_rdata = st_q.txstat;
                IX_STATUS: reg_rdata = isr_q;
                IX_TXPG_R: reg_rdata = st_q.txpage;
                IX_MASK_R: reg_rdata = st_q.mask;
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign tx_start = st_q.tx_go;
    assign tx_addr  = st_q.tx_addr;
    assign tx_len   = st_q.tx_len;
endmodule

// File: rtl/nic_ctrl_checker.sv
`timescale 1ns/1ps
module nic_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       rst_port_rd,
    input logic [7:0] hw_set,
    input logic [7:0] status,
    input logic [7:0] mask,
    input logic       irq,
    input logic       tx_start
);
    p_tx_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    p_tx_follows_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd0 && reg_wdata[2] && reg_wdata[1]) |=> tx_start);

    p_tx_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !$past(rst_port_rd)) |-> status[1]);

    p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_port_rd) |-> ((status & $past(hw_set)) == $past(hw_set)));

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_port_rd) |-> (status == 8'h80));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);
endmodule

bind nic_ctrl_core nic_ctrl_checker i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .rst_port_rd (rst_port_rd),
    .hw_set      (hw_set),
    .status      (isr_q),
    .mask        (st_q.mask),
    .irq         (irq),
    .tx_start    (tx_start)
);

// File: tb/test_nic_ctrl_core.sv
`timescale 1ns/1ps
module test_nic_ctrl_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rst_port_rd = 1'b0;
    logic [7:0]  hw_set = '0;
    logic        irq, tx_start;
    logic [15:0] tx_addr, tx_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nic_ctrl_core i_nic_ctrl_core (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        rd(4'd0, v); check("R1 cmd", v, 8'h01);
        rd(4'd7, v); check("R1 status", v, 8'h80);
        check("R1 irq", irq, 1'b0);
        check("R1 tx_start", tx_start, 1'b0);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R1 mask", v, 8'h00);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_pages();
        logic [7:0] v;
        wr(4'd0, 8'h40);
        rd(4'd0, v); check("R2 cmd on page1", v, 8'h40);
        wr(4'd1, 8'hA5);
        wr(4'd7, 8'h3C);
        wr(4'd15, 8'h5A);
        rd(4'd1, v); check("R3 station byte", v, 8'hA5);
        rd(4'd7, v); check("R3 current page", v, 8'h3C);
        rd(4'd15, v); check("R3 multicast byte", v, 8'h5A);
        wr(4'd0, 8'h00);
        rd(4'd7, v); check("R3 page0 status untouched", v, 8'h80);
        rd(4'd1, v); check("R2 page0 offset1", v, 8'h00);
        wr(4'd0, 8'hC0);
        wr(4'd1, 8'h33);
        wr(4'd15, 8'hFF);
        rd(4'd1, v); check("R4 page3 read", v, 8'h00);
        rd(4'd0, v); check("R2 cmd on page3", v, 8'hC0);
        wr(4'd0, 8'h40);
        rd(4'd1, v); check("R4 page1 kept", v, 8'hA5);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R4 mask kept", v, 8'h00);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_status_irq();
        logic [7:0] v;
        wr(4'd7, 8'h80);
        rd(4'd7, v); check("R5 clear reset bit", v, 8'h00);
        @(negedge clk); hw_set = 8'h05;
        @(negedge clk); hw_set = 8'h00;
        rd(4'd7, v); check("R6 events set", v, 8'h05);
        wr(4'd7, 8'h01);
        rd(4'd7, v); check("R5 write-one clear", v, 8'h04);
        check("R7 irq masked", irq, 1'b0);
        wr(4'd15, 8'h04);
        check("R7 irq unmasked", irq, 1'b1);
        wr(4'd15, 8'h01);
        check("R7 irq other bit", irq, 1'b0);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R7 mask readback", v, 8'h01);
        wr(4'd0, 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 8'h04; hw_set = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; hw_set = 8'h00;
        rd(4'd7, v); check("R6 set beats clear", v, 8'h04);
        wr(4'd7, 8'hFF);
        rd(4'd7, v); check("R5 clear all", v, 8'h00);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        wr(4'd4, 8'h40);
        wr(4'd5, 8'h34);
        wr(4'd6, 8'h12);
        wr(4'd5, 8'h78);
        wr(4'd0, 8'h04);
        check("R9 no pulse without start", tx_start, 1'b0);
        rd(4'd7, v); check("R9 no TX bit without start", v, 8'h00);
        wr(4'd0, 8'h06);
        check("R9 pulse high", tx_start, 1'b1);
        check("R9 tx_addr", tx_addr, 16'h4000);
        check("R8 tx_len halves", tx_len, 16'h1278);
        @(negedge clk);
        check("R9 pulse one cycle", tx_start, 1'b0);
        rd(4'd7, v); check("R9 TX status bit", v, 8'h02);
        rd(4'd4, v); check("R9 transmit status", v, 8'h01);
        wr(4'd0, 8'h82);
        rd(4'd4, v); check("R8 start page readback", v, 8'h40);
        wr(4'd0, 8'h02);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        wr(4'd0, 8'h42);
        @(negedge clk); rst_port_rd = 1'b1;
        @(negedge clk); rst_port_rd = 1'b0;
        rd(4'd0, v); check("R10 cmd", v, 8'h01);
        rd(4'd7, v); check("R10 status", v, 8'h80);
        wr(4'd0, 8'h40);
        rd(4'd1, v); check("R10 page1 kept", v, 8'hA5);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R10 mask kept", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_pages();
        t_status_irq();
        t_transmit();
        t_soft_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule